// File: doc/BRIEF.md
# ADC Conversion Group Status Register

This block holds the status word for one conversion group of a multi-group ADC sequencer. The sequencer sends it single-cycle event strobes: group start, channel done (with a last-channel qualifier), freeze, resume and result written. It also sends a level that says the group runs in continuous mode. From these events the block keeps four flags: conversions ended, conversions stopped (frozen), group busy, and results memory empty. Software reads them as one 32-bit word.

The register bus can clear the ended flag by writing a 1 to bit 0. Three other events also clear it: a result read from the group memory in FIFO mode, a write to the group's channel-select register, and clearing the module enable. The empty flag comes from a saturating count of results written and not yet read. While the module enable is low, the block holds every flag at its idle value and ignores all sequencer events.

Top module: `adc_group_status`

## Requirements
- R1: `rdData` bit 0 is the ended flag, bit 1 the stopped flag, bit 2 the busy flag and bit 3 the empty flag. Bits 31 to 4 always read 0.
- R2: After reset `rdData` equals 32'h0000_0008: empty is 1 and ended, stopped and busy are 0.
- R3: The ended flag sets on the edge after a cycle in which `evChanDone` and `evLastChan` are both high. `evChanDone` with `evLastChan` low leaves the ended flag unchanged.
- R4: The ended flag clears on the edge after any of the following: `fifoRead` high; `selWrite` high; `wrEn` high with `wrData[0]` = 1; `modEnable` low. A write with `wrData[0]` = 0 changes no flag, whatever bits 31 to 1 hold.
- R5: When a set and a clear of the ended flag meet in one cycle, the ended flag becomes 1.
- R6: `evStart` makes busy 1 on the next edge. Busy returns to 0 on the edge after a group completion (R3) only if the group is not frozen and not in continuous mode. If `evStart` and a completion arrive in the same cycle, the group stays running.
- R7: `evFreeze` sets the stopped flag only while the group is running or `contMode` is high. `evResume` clears it and wins over a simultaneous `evFreeze`. While the stopped flag is 1, busy is 1.
- R8: While `contMode` is high and the module is enabled, busy reads 1 from the next edge on.
- R9: The unread count rises on `resWrite` and falls on `fifoRead`. It saturates at `RESULT_DEPTH` and ignores a read at zero; a write and a valid read in the same cycle cancel. The empty flag is 1 exactly when the count is 0.
- R10: On the edge after `modEnable` is low, `rdData` is 32'h0000_0008. While `modEnable` is low, the block ignores every sequencer event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modEnable | input | 1 | Module enable level |
| evStart | input | 1 | Group conversion start strobe |
| evChanDone | input | 1 | One channel finished converting |
| evLastChan | input | 1 | Qualifies `evChanDone` as the group's last channel |
| evFreeze | input | 1 | Group frozen to serve another group |
| evResume | input | 1 | Group released from freeze |
| contMode | input | 1 | Group configured for continuous conversion |
| resWrite | input | 1 | One result written to group memory |
| fifoRead | input | 1 | One result read from group memory in FIFO mode |
| selWrite | input | 1 | Group channel-select register written |
| wrEn | input | 1 | Bus write to this status register |
| wrData | input | 32 | Bus write data; only bit 0 acts, as write-one-to-clear |
| rdData | output | 32 | Status word |

## Verification
The bench builds the block with `RESULT_DEPTH` = 4. With that small depth, a few bursts of result writes reach the saturation limit, and the empty flag returns to 1 within the random run. The default `DATA_W` of 32 keeps the reserved upper bits on the read path, so each cycle checks them. Directed sequences cover the set-versus-clear collision, resume-over-freeze, start-with-completion and disable while frozen. A seeded random run then mixes all events, with the enable dropping now and then.

// File: rtl/grp_stat_pkg.sv
package grp_stat_pkg;

  // Strobes issued by the control decoder to the flag datapath
  typedef struct packed {
    logic flush;     // module disabled: return everything to idle
    logic endSet;    // group completion
    logic endClr;    // any clear source of the ended flag
    logic runSet;    // group start
    logic runClr;    // group completion
    logic frzSet;    // freeze accepted
    logic frzClr;    // resume
    logic contHold;  // continuous mode keeps busy high
    logic cntUp;     // unread count increment
    logic cntDown;   // unread count decrement
  } statStrobe_t;

  localparam int END_BIT   = 0;
  localparam int STOP_BIT  = 1;
  localparam int BUSY_BIT  = 2;
  localparam int EMPTY_BIT = 3;

endpackage

// File: rtl/grp_stat_ctrl.sv
module grp_stat_ctrl
  import grp_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        modEnable,
  input  logic        evStart,
  input  logic        evChanDone,
  input  logic        evLastChan,
  input  logic        evFreeze,
  input  logic        evResume,
  input  logic        contMode,
  input  logic        resWrite,
  input  logic        fifoRead,
  input  logic        selWrite,
  input  logic        wrEn,
  input  logic        wrBit0,
  input  logic        runQ,
  input  logic        cntZero,
  input  logic        cntFull,
  output statStrobe_t stb
);

  logic groupDone;
  logic readOk;

  always_comb begin
    groupDone = modEnable && evChanDone && evLastChan;
    readOk    = modEnable && fifoRead && !cntZero;

    stb          = '0;
    stb.flush    = !modEnable;
    stb.endSet   = groupDone;
    stb.endClr   = !modEnable || fifoRead || selWrite || (wrEn && wrBit0);
    stb.runSet   = modEnable && evStart;
    stb.runClr   = groupDone;
    stb.frzClr   = modEnable && evResume;
    stb.frzSet   = modEnable && evFreeze && (runQ || contMode);
    stb.contHold = modEnable && contMode;
    stb.cntDown  = readOk;
    stb.cntUp    = modEnable && resWrite && (!cntFull || readOk);
  end

  // R9: a decrement is never requested at zero
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    cntZero |-> !stb.cntDown);

  // R9: an increment at the limit only comes paired with a decrement
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cntFull && stb.cntUp) |-> stb.cntDown);

endmodule

// File: rtl/grp_stat_dp.sv
module grp_stat_dp
  import grp_stat_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int RESULT_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  statStrobe_t       stb,
  output logic              runQ,
  output logic              cntZero,
  output logic              cntFull,
  output logic [DATA_W-1:0] rdData
);

  localparam int CNT_W = $clog2(RESULT_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RESULT_DEPTH);

  logic             endQ;
  logic             frzQ;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             runNext;
  logic             frzNext;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    if (stb.flush)        runNext = 1'b0;
    else if (stb.runSet)  runNext = 1'b1;
    else if (stb.runClr)  runNext = 1'b0;
    else                  runNext = runQ;

    if (stb.flush)        frzNext = 1'b0;
    else if (stb.frzClr)  frzNext = 1'b0;
    else if (stb.frzSet)  frzNext = 1'b1;
    else                  frzNext = frzQ;

    if (stb.flush)                      cntNext = '0;
    else if (stb.cntUp && !stb.cntDown) cntNext = cntQ + 1'b1;
    else if (stb.cntDown && !stb.cntUp) cntNext = cntQ - 1'b1;
    else                                cntNext = cntQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ  <= 1'b0;
      frzQ  <= 1'b0;
      busyQ <= 1'b0;
      endQ  <= 1'b0;
      cntQ  <= '0;
    end else begin
      runQ  <= runNext;
      frzQ  <= frzNext;
      busyQ <= !stb.flush && (runNext || frzNext || stb.contHold);
      cntQ  <= cntNext;
      if (stb.endSet)      endQ <= 1'b1;
      else if (stb.endClr) endQ <= 1'b0;
    end
  end

  assign cntZero = (cntQ == '0);
  assign cntFull = (cntQ == CNT_MAX);

  always_comb begin
    rdData            = '0;
    rdData[END_BIT]   = endQ;
    rdData[STOP_BIT]  = frzQ;
    rdData[BUSY_BIT]  = busyQ;
    rdData[EMPTY_BIT] = cntZero;
  end

  // R5: a completion is never lost to a clear in the same cycle
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stb.endSet |=> endQ);

  // R4: a lone clear source drops the ended flag
  a_r4_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.endClr && !stb.endSet) |=> !endQ);

  // R7: a frozen group always reports busy
  a_r7_stop_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    frzQ |-> busyQ);

  // R8: continuous mode holds busy
  a_r8_cont_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stb.contHold |=> busyQ);

  // R10: disable returns to the idle word
  a_r10_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stb.flush |=> (cntZero && !busyQ && !frzQ && !endQ));

  // R9: count stays within the result depth
  a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= CNT_MAX);

endmodule

// File: rtl/adc_group_status.sv
module adc_group_status
  import grp_stat_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int RESULT_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modEnable,
  input  logic              evStart,
  input  logic              evChanDone,
  input  logic              evLastChan,
  input  logic              evFreeze,
  input  logic              evResume,
  input  logic              contMode,
  input  logic              resWrite,
  input  logic              fifoRead,
  input  logic              selWrite,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  statStrobe_t stb;
  logic        runQ;
  logic        cntZero;
  logic        cntFull;
  logic        unusedWrHigh;

  // R1, R4: only bit 0 of a write acts; the rest is ignored
  assign unusedWrHigh = ^wrData[DATA_W-1:1];

  grp_stat_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .modEnable  (modEnable),
    .evStart    (evStart),
    .evChanDone (evChanDone),
    .evLastChan (evLastChan),
    .evFreeze   (evFreeze),
    .evResume   (evResume),
    .contMode   (contMode),
    .resWrite   (resWrite),
    .fifoRead   (fifoRead),
    .selWrite   (selWrite),
    .wrEn       (wrEn),
    .wrBit0     (wrData[0]),
    .runQ       (runQ),
    .cntZero    (cntZero),
    .cntFull    (cntFull),
    .stb        (stb)
  );

  grp_stat_dp #(
    .DATA_W       (DATA_W),
    .RESULT_DEPTH (RESULT_DEPTH)
  ) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .runQ    (runQ),
    .cntZero (cntZero),
    .cntFull (cntFull),
    .rdData  (rdData)
  );

  // R1: reserved bits never read as 1
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[DATA_W-1:4] == '0);

endmodule

// File: tb/test_adc_group_status.sv
module test_adc_group_status;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        modEnable, evStart, evChanDone, evLastChan, evFreeze, evResume;
  logic        contMode, resWrite, fifoRead, selWrite, wrEn;
  logic [31:0] wrData;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;

  // bench model state
  bit mEnd, mRun, mFrz, mBusy;
  int mCnt;

  always #2 clk = ~clk;

  adc_group_status #(.DATA_W(32), .RESULT_DEPTH(DEPTH)) i_adc_group_status (
    .clk(clk), .rst_n(rst_n), .modEnable(modEnable), .evStart(evStart),
    .evChanDone(evChanDone), .evLastChan(evLastChan), .evFreeze(evFreeze),
    .evResume(evResume), .contMode(contMode), .resWrite(resWrite),
    .fifoRead(fifoRead), .selWrite(selWrite), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData)
  );

  function automatic logic [31:0] expWord();
    return {28'd0, (mCnt == 0), mBusy, mFrz, mEnd};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    evStart = 0; evChanDone = 0; evLastChan = 0; evFreeze = 0; evResume = 0;
    resWrite = 0; fifoRead = 0; selWrite = 0; wrEn = 0; wrData = '0;
  endtask

  // next state from the requirements
  task automatic modelStep();
    bit en, done, rdOk, runN, frzN, clr;
    en   = modEnable;
    done = en && evChanDone && evLastChan;
    clr  = !en || fifoRead || selWrite || (wrEn && wrData[0]);
    if (!en) runN = 0; else if (evStart) runN = 1; else if (done) runN = 0; else runN = mRun;
    if (!en) frzN = 0; else if (evResume) frzN = 0;
    else if (evFreeze && (mRun || contMode)) frzN = 1; else frzN = mFrz;
    if (done) mEnd = 1; else if (clr) mEnd = 0;
    rdOk = en && fifoRead && (mCnt > 0);
    if (!en) mCnt = 0;
    else if (resWrite && rdOk) mCnt = mCnt;
    else if (resWrite && mCnt < DEPTH) mCnt = mCnt + 1;
    else if (rdOk) mCnt = mCnt - 1;
    mBusy = en && (runN || frzN || contMode);
    mRun = runN;
    mFrz = frzN;
  endtask

  task automatic cyc(string tag);
    modelStep();
    @(posedge clk); #1;
    chk({tag, " word"}, rdData, expWord());
    chk("R1 reserved", {4'd0, rdData[31:4]}, 32'd0);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); modEnable = 1; contMode = 0;
    mEnd = 0; mRun = 0; mFrz = 0; mBusy = 0; mCnt = 0;
    repeat (3) @(negedge clk);
    chk("R2 in reset", rdData, 32'h8);
    rst_n = 1;
    @(negedge clk);
    chk("R2 after reset", rdData, 32'h0000_0008);

    // R6 start -> busy; R3 non-last channel leaves end
    evStart = 1; cyc("R6 start");
    chk("R6 busy", {31'd0, rdData[2]}, 32'd1);
    evChanDone = 1; cyc("R3 mid channel");
    chk("R3 no end", {31'd0, rdData[0]}, 32'd0);
    evChanDone = 1; evLastChan = 1; cyc("R3 last channel");
    chk("R3 end set / R6 busy drop", rdData, 32'h9);

    // R4 write with bit0 = 0 ignored, then W1C
    wrEn = 1; wrData = 32'hFFFF_FFFE; cyc("R4 write zero bit");
    chk("R4 end kept", rdData, 32'h9);
    wrEn = 1; wrData = 32'h1; cyc("R4 w1c");
    chk("R4 w1c cleared", rdData, 32'h8);

    // R5 set vs clear same cycle
    evStart = 1; cyc("R6 restart");
    evChanDone = 1; evLastChan = 1; selWrite = 1; cyc("R5 collide");
    chk("R5 set wins", {31'd0, rdData[0]}, 32'd1);
    selWrite = 1; cyc("R4 select write");
    chk("R4 sel clear", {31'd0, rdData[0]}, 32'd0);

    // R6 start with completion keeps running
    evStart = 1; cyc("R6 start");
    evStart = 1; evChanDone = 1; evLastChan = 1; cyc("R6 start+done");
    chk("R6 still busy", {31'd0, rdData[2]}, 32'd1);

    // R7 freeze/resume
    evFreeze = 1; cyc("R7 freeze");
    chk("R7 stopped busy", rdData & 32'h6, 32'h6);
    evChanDone = 1; evLastChan = 1; cyc("R7 done while frozen");
    chk("R7 busy while frozen", rdData & 32'h6, 32'h6);
    evFreeze = 1; evResume = 1; cyc("R7 resume wins");
    chk("R7 resumed idle", rdData & 32'h6, 32'h0);
    evFreeze = 1; cyc("R7 idle freeze");
    chk("R7 freeze ignored", {31'd0, rdData[1]}, 32'd0);

    // R8 continuous
    contMode = 1; cyc("R8 cont");
    chk("R8 busy held", {31'd0, rdData[2]}, 32'd1);
    contMode = 0; @(negedge clk); idle(); cyc("R8 cont off");

    // R9 counter saturation and read-at-zero
    for (int i = 0; i < DEPTH + 2; i++) begin resWrite = 1; cyc("R9 fill"); end
    chk("R9 not empty", {31'd0, rdData[3]}, 32'd0);
    for (int i = 0; i < DEPTH - 1; i++) begin fifoRead = 1; cyc("R9 drain"); end
    chk("R9 one left", {31'd0, rdData[3]}, 32'd0);
    resWrite = 1; fifoRead = 1; cyc("R9 cancel");
    fifoRead = 1; cyc("R9 last read");
    chk("R9 empty", {31'd0, rdData[3]}, 32'd1);
    fifoRead = 1; cyc("R9 read at zero");
    resWrite = 1; fifoRead = 1; cyc("R9 write+read at zero");
    chk("R9 count one", {31'd0, rdData[3]}, 32'd0);

    // R10 disable while frozen and ended
    evStart = 1; resWrite = 1; cyc("R10 prep");
    evFreeze = 1; evChanDone = 1; evLastChan = 1; cyc("R10 prep2");
    modEnable = 0; contMode = 1; cyc("R10 disable");
    chk("R10 idle word", rdData, 32'h8);
    evStart = 1; resWrite = 1; evChanDone = 1; evLastChan = 1; evFreeze = 1;
    cyc("R10 ignored");
    chk("R10 events ignored", rdData, 32'h8);
    modEnable = 1; contMode = 0; @(negedge clk); idle(); cyc("R10 enable");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      evStart    = ($urandom % 8) == 0;
      evChanDone = ($urandom % 3) == 0;
      evLastChan = ($urandom % 2) == 0;
      evFreeze   = ($urandom % 6) == 0;
      evResume   = ($urandom % 6) == 0;
      resWrite   = ($urandom % 3) == 0;
      fifoRead   = ($urandom % 4) == 0;
      selWrite   = ($urandom % 16) == 0;
      wrEn       = ($urandom % 8) == 0;
      wrData     = $urandom;
      if (($urandom % 50) == 0) contMode = ~contMode;
      modEnable  = ($urandom % 40) != 0;
      cyc("R3 R4 R6 R7 R8 R9 R10 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule